// File: doc/BRIEF.md
# Any-Fault Interrupt Combiner with Glitch Filter and Pulse Stretcher

This block merges a set of active-low fault lines into a single active-high interrupt request. Each line is first brought into the local clock domain through a synchronizer chain, then the lines are combined: a low level on any one of them counts as a fault. The combined fault must stay present for a programmable number of consecutive clock samples before it is trusted. Shorter disturbances are discarded as glitches.

A fault that passes the filter raises the interrupt at once. The interrupt stays raised for as long as the qualified fault lasts. After the fault clears, it is held high for a further programmable number of cycles, so that a slowly polling controller still sees even a brief real fault. A fault that returns while this tail is running lengthens the pulse without any low gap. The glitch window and the stretch length are independent inputs, and both are expected to stay constant while the block is running.

Top module: `fault_irq_merger`

## Requirements
- R1: Every bit of `fault_n_i` is active-low: a 0 on any single bit is a fault, and with all bits at 1 the block sees no fault.
- R2: The inputs pass a two-stage synchronizer. With a glitch minimum of M (M >= 1), a fault driven just before clock edge 1 raises `irq_o` first after edge M+3.
- R3: A combined fault that lasts fewer than max(M,1) consecutive clock samples never raises `irq_o`.
- R4: A combined fault that lasts exactly max(M,1) samples raises `irq_o`. `irq_o` rises only in the cycle after a qualified fault.
- R5: `irq_o` stays high for as long as the qualified fault is present.
- R6: A fault lasting N >= max(M,1) samples, with stretch S, holds `irq_o` high for exactly N - max(M,1) + 1 + S consecutive cycles.
- R7: A fault that returns while the stretch tail is running extends the pulse, and no low cycle appears between the two parts.
- R8: While `rst_i` is high, and in the cycle after it, `irq_o` is 0.
- R9: A glitch minimum of 0 behaves the same as a minimum of 1: a single-sample fault is accepted.
- R10: With a stretch of 0, the pulse width is N - max(M,1) + 1, so `irq_o` follows the qualified fault with no tail.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| fault_n_i | input | NUM_IN | Active-low fault lines, asynchronous to the clock |
| cfg_glitch_min_i | input | CNT_W | Minimum fault duration to accept, in clock samples |
| cfg_stretch_i | input | CNT_W | Extra cycles `irq_o` is held high after the fault clears |
| irq_o | output | 1 | Active-high merged fault interrupt |

## Verification
A fault on the inputs needs two edges to cross the synchronizer and M more edges to qualify. It then needs one more edge to register in the output stage, so the first high `irq_o` is due after edge M+3. The release is due S edges after the qualifier drops. The bench drives inputs on falling edges and samples `irq_o` on the next falling edge, where it holds the value set by the preceding rising edge. The directed cases therefore count rising edges exactly against these figures. During the random phase, a cycle-level reference built from the requirements is compared against `irq_o` at every falling edge.

// File: rtl/fltc_pkg.sv
package fltc_pkg;

    localparam int SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        STR_IDLE = 2'd0,
        STR_HOLD = 2'd1,
        STR_TAIL = 2'd2
    } str_state_e;

    typedef struct packed {
        str_state_e state;
        logic       irq;
    } str_view_t;

    function automatic logic str_is_active(input str_state_e s);
        return (s != STR_IDLE);
    endfunction

endpackage

// File: rtl/fltc_sync.sv
module fltc_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int k = 0; k < STAGES; k++) stg_q[k] <= '1;
        end else begin
            stg_q[0] <= d_i;
            for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/fltc_deglitch.sv
module fltc_deglitch #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             fault_i,
    input  logic [CNT_W-1:0] min_i,
    output logic             qual_o
);
    logic [CNT_W-1:0] run_q;
    logic [CNT_W:0]   run_inc;

    assign run_inc = {1'b0, run_q} + 1'b1;

    always_ff @(posedge clk_i) begin
        if (rst_i || !fault_i) begin
            run_q  <= '0;
            qual_o <= 1'b0;
        end else begin
            if (run_q != '1) run_q <= run_inc[CNT_W-1:0];
            qual_o <= (run_inc >= {1'b0, min_i});
        end
    end

    // A qualified fault can only follow a sampled combined fault
    assert_qual_needs_fault_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        qual_o |-> $past(fault_i));

    // Qualification persists while the fault persists
    assert_qual_sticky_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (qual_o && fault_i) |=> qual_o);
endmodule

// File: rtl/fltc_stretch.sv
module fltc_stretch #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             qual_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             irq_o
);
    import fltc_pkg::*;

    str_state_e       st_q;
    logic [CNT_W-1:0] rem_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q  <= STR_IDLE;
            rem_q <= '0;
        end else if (qual_i) begin
            st_q  <= STR_HOLD;
            rem_q <= len_i;
        end else begin
            case (st_q)
                STR_HOLD, STR_TAIL: begin
                    if (rem_q == '0) begin
                        st_q <= STR_IDLE;
                    end else begin
                        st_q  <= STR_TAIL;
                        rem_q <= rem_q - 1'b1;
                    end
                end
                default: st_q <= STR_IDLE;
            endcase
        end
    end

    assign irq_o = str_is_active(st_q);

    assert_irq_during_qual_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        qual_i |=> irq_o);

    assert_rise_after_qual_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(irq_o) |-> $past(qual_i));

    assert_tail_present_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        ($fell(qual_i) && len_i != '0) |=> irq_o);
endmodule

// File: rtl/fault_irq_merger.sv
module fault_irq_merger #(
    parameter int NUM_IN = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [NUM_IN-1:0] fault_n_i,
    input  logic [CNT_W-1:0]  cfg_glitch_min_i,
    input  logic [CNT_W-1:0]  cfg_stretch_i,
    output logic              irq_o
);
    import fltc_pkg::*;

    logic [NUM_IN-1:0] fault_n_sync;
    logic              any_fault;
    logic              fault_qual;

    fltc_sync #(.W(NUM_IN), .STAGES(SYNC_DEPTH)) sync_i (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (fault_n_i),
        .q_o   (fault_n_sync)
    );

    assign any_fault = |(~fault_n_sync);

    fltc_deglitch #(.CNT_W(CNT_W)) deglitch_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .fault_i (any_fault),
        .min_i   (cfg_glitch_min_i),
        .qual_o  (fault_qual)
    );

    fltc_stretch #(.CNT_W(CNT_W)) stretch_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .qual_i (fault_qual),
        .len_i  (cfg_stretch_i),
        .irq_o  (irq_o)
    );

    assert_idle_after_reset_R8: assert property (@(posedge clk_i)
        rst_i |=> !irq_o);
endmodule

// File: tb/fault_irq_merger_tb_top.sv
`timescale 1ns/1ps
module fault_irq_merger_tb_top;
    localparam int NUM_IN = 4;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NUM_IN-1:0] fault_n = '1;
    logic [CNT_W-1:0]  gmin = 16'd4;
    logic [CNT_W-1:0]  strc = 16'd10;
    logic              irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    fault_irq_merger #(.NUM_IN(NUM_IN), .CNT_W(CNT_W)) dut_i (
        .clk_i            (clk),
        .rst_i            (rst),
        .fault_n_i        (fault_n),
        .cfg_glitch_min_i (gmin),
        .cfg_stretch_i    (strc),
        .irq_o            (irq)
    );

    // Requirement-level reference: two sample delay, run length, stretch tail
    bit m_d1, m_d2, m_q, m_exp;
    int m_run, m_rem;

    function automatic int eff_min(input int m);
        return (m < 1) ? 1 : m;
    endfunction

    function automatic int exp_width(input int n, input int m, input int s);
        return (n >= eff_min(m)) ? (n - eff_min(m) + 1 + s) : 0;
    endfunction

    always @(posedge clk) begin
        bit used;
        if (rst) begin
            m_d1 = 0; m_d2 = 0; m_q = 0; m_exp = 0; m_run = 0; m_rem = 0;
        end else begin
            used  = m_d2;
            m_d2  = m_d1;
            m_d1  = (fault_n != '1);
            if (m_q) begin
                m_exp = 1; m_rem = int'(strc);
            end else if (m_rem > 0) begin
                m_exp = 1; m_rem--;
            end else begin
                m_exp = 0;
            end
            m_run = used ? m_run + 1 : 0;
            m_q   = (m_run >= eff_min(int'(gmin)));
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; fault_n = '1;
        repeat (3) @(negedge clk);
        check(irq == 1'b0, "R8 irq low in reset", irq, 0);
        rst = 1'b0;
        @(negedge clk);
        check(irq == 1'b0, "R8 irq low after reset", irq, 0);
    endtask

    // Two pulses: first of len1 on mask1 from iteration 0, second of len2 on mask2 from start2
    task automatic run_pulses(input logic [NUM_IN-1:0] mask1, input int len1,
                              input logic [NUM_IN-1:0] mask2, input int start2, input int len2,
                              input int window, output int width, output int rises,
                              output int first_hi);
        bit prev = 1'b0;
        width = 0; rises = 0; first_hi = -1;
        for (int i = 0; i < window; i++) begin
            @(negedge clk);
            if (irq) begin
                width++;
                if (first_hi < 0) first_hi = i;
            end
            if (irq && !prev) rises++;
            prev = irq;
            fault_n = '1;
            if (i < len1) fault_n = fault_n & ~mask1;
            if (i >= start2 && i < start2 + len2) fault_n = fault_n & ~mask2;
        end
        fault_n = '1;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int w, r, f;
        void'($urandom(32'h5EED_0042));
        gmin = 16'd4; strc = 16'd10;
        do_reset();

        // R1: each line alone triggers; R6 width
        for (int ch = 0; ch < NUM_IN; ch++) begin
            run_pulses(4'(1 << ch), 6, '0, 0, 0, 60, w, r, f);
            check(w == exp_width(6, 4, 10), $sformatf("R1 R6 width on line %0d", ch), w, exp_width(6, 4, 10));
            if (ch == 0) check(f == 4 + 3, "R2 rise latency", f, 7);
        end
        // R3: too short
        run_pulses(4'b0110, 3, '0, 0, 0, 40, w, r, f);
        check(w == 0, "R3 short pulse rejected", w, 0);
        // R4: exactly minimum
        run_pulses(4'b0001, 4, '0, 0, 0, 40, w, r, f);
        check(w == exp_width(4, 4, 10), "R4 minimum pulse accepted", w, exp_width(4, 4, 10));
        // R5: long fault keeps irq high
        run_pulses(4'b1000, 40, '0, 0, 0, 80, w, r, f);
        check(w == exp_width(40, 4, 10) && r == 1, "R5 held during long fault", w, exp_width(40, 4, 10));
        // R7: second fault during tail: one continuous pulse 7..30
        run_pulses(4'b0001, 6, 4'b0100, 11, 6, 60, w, r, f);
        check(r == 1, "R7 no gap rises", r, 1);
        check(w == 24, "R7 merged width", w, 24);
        // R9: minimum 0 acts as 1
        gmin = 16'd0; do_reset();
        run_pulses(4'b0010, 1, '0, 0, 0, 40, w, r, f);
        check(w == exp_width(1, 0, 10), "R9 zero minimum accepts one sample", w, exp_width(1, 0, 10));
        check(f == 4, "R9 R2 latency with minimum 0", f, 4);
        // R10: no stretch
        gmin = 16'd2; strc = 16'd0; do_reset();
        run_pulses(4'b0100, 5, '0, 0, 0, 40, w, r, f);
        check(w == exp_width(5, 2, 0), "R10 zero stretch width", w, exp_width(5, 2, 0));
        run_pulses(4'b0100, 1, '0, 0, 0, 40, w, r, f);
        check(w == 0, "R3 one sample below minimum 2", w, 0);

        // Random phase against reference (R1 R3 R5 R6 R7)
        gmin = 16'd3; strc = 16'd7; do_reset();
        for (int b = 0; b < 300; b++) begin
            int len = 1 + int'($urandom_range(0, 11));
            int gap = 1 + int'($urandom_range(0, 19));
            logic [NUM_IN-1:0] msk = NUM_IN'($urandom_range(1, (1 << NUM_IN) - 1));
            for (int i = 0; i < len + gap; i++) begin
                @(negedge clk);
                check(irq == m_exp, "R6 random reference compare", irq, m_exp);
                fault_n = (i < len) ? ~msk : '1;
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule